// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a physical address for a processor that uses four 16-bit segment registers and no memory protection. The segment registers are the code, data, stack and extra registers. Each request carries an addressing-mode code. The code says how the offset was produced: an instruction fetch, a push or pop, a string destination, or one of the base/index register forms. The block picks the segment register implicitly from that code, unless a valid override selects another one. It then shifts the chosen segment value left by four bits and adds the offset. Segments are 64 KiB windows that may overlap, and no limit is checked.

A write port can reload the segment registers at any time. The address is registered: it appears one clock after the request, together with the 2-bit index of the segment that was used. The adder keeps the full 21-bit sum. A parameter can instead fold the result to 20 bits, so that an address above the 1 MiB boundary wraps back to zero.

Top module: `rmag_top`

## Requirements
- R1: While reset is asserted, `out_valid`, `out_addr` and `out_seg` are zero. All four segment registers reset to zero, so the first request after reset returns its bare offset.
- R2: For a request in cycle N, `out_addr` in cycle N+1 is (segment << 4) + offset, computed to 21 bits. A carry out of bit 19 appears in bit 20.
- R3: With `WRAP_1M` = 1, bit 20 of `out_addr` is always zero and the sum wraps modulo 2^20.
- R4: `out_valid` is high exactly one cycle after a cycle with `req_valid` high. After a cycle without a request, `out_valid` is low and `out_addr` and `out_seg` keep their previous values.
- R5: Mode 0 (instruction fetch) always uses the code segment. Mode 1 (push/pop) always uses the stack segment. The override has no effect on either mode.
- R6: Without an override, mode 3 (stack-pointer based), mode 4 (base-pointer based) and mode 8 (base pointer plus an index register) use the stack segment.
- R7: Without an override, mode 5 (BX based), mode 6 (SI based), mode 7 (DI based), mode 9 (BX plus an index register) and the unused modes 10 to 15 use the data segment.
- R8: Mode 2 (string destination) always uses the extra segment. A valid override is ignored for this mode.
- R9: For modes 3 to 15, `ovr_valid` high makes `ovr_sel` the segment used.
- R10: With `seg_wr_en` high, `seg_wr_data` is loaded into the register `seg_wr_sel` at the clock edge. A request in the same cycle still uses the old value, and requests in later cycles use the new one.
- R11: `out_seg` reports the segment used, coded as 0 = code, 1 = data, 2 = stack, 3 = extra. The same coding applies to `ovr_sel` and `seg_wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Load a segment register |
| seg_wr_sel | input | 2 | Segment register to load |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request |
| req_mode | input | 4 | Addressing-mode code |
| req_offset | input | 16 | Within-segment offset |
| ovr_valid | input | 1 | Override present |
| ovr_sel | input | 2 | Override segment |
| out_valid | output | 1 | Address valid |
| out_addr | output | 21 | Physical address |
| out_seg | output | 2 | Segment used |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the default `WRAP_1M` = 0, which makes the carry into bit 20 observable. The other uses `WRAP_1M` = 1, which shows the 1 MiB fold on the same inputs, including the corner case of segment 0xFFFF with offset 0xFFFF. Both copies keep the 16-bit offset and four segments, so every mode code and every override value can be reached.

// File: rtl/rmag_pkg.sv
package rmag_pkg;

    localparam int SEG_N   = 4;
    localparam int SEG_W   = 2;
    localparam int MODE_W  = 4;

    typedef enum logic [SEG_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_e;

    localparam logic [MODE_W-1:0] AM_FETCH   = 4'd0;
    localparam logic [MODE_W-1:0] AM_STACKOP = 4'd1;
    localparam logic [MODE_W-1:0] AM_STRDST  = 4'd2;
    localparam logic [MODE_W-1:0] AM_SP      = 4'd3;
    localparam logic [MODE_W-1:0] AM_BP      = 4'd4;
    localparam logic [MODE_W-1:0] AM_BX      = 4'd5;
    localparam logic [MODE_W-1:0] AM_SI      = 4'd6;
    localparam logic [MODE_W-1:0] AM_DI      = 4'd7;
    localparam logic [MODE_W-1:0] AM_BPIDX   = 4'd8;
    localparam logic [MODE_W-1:0] AM_BXIDX   = 4'd9;

endpackage

// File: rtl/rmag_segfile.sv
module rmag_segfile #(
    parameter int NUM = 4,
    parameter int DW  = 16,
    localparam int SW = $clog2(NUM)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SW-1:0]           wr_sel,
    input  logic [DW-1:0]           wr_data,
    output logic [NUM-1:0][DW-1:0]  seg_q
);

    logic [NUM-1:0][DW-1:0] seg_d;

    always_comb begin
        seg_d = seg_q;
        for (int i = 0; i < NUM; i++) begin
            if (wr_en && (wr_sel == SW'(i))) begin
                seg_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= '0;
        end else begin
            seg_q <= seg_d;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_q[$past(wr_sel)] == $past(wr_data)); // R10

endmodule

// File: rtl/rmag_select.sv
module rmag_select
    import rmag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              ovr_valid,
    input  logic [SEG_W-1:0]  ovr_sel,
    output logic [SEG_W-1:0]  seg_sel
);

    seg_e implicit_seg;

    always_comb begin
        case (mode)
            AM_SP, AM_BP, AM_BPIDX: implicit_seg = SEG_STACK;
            default:                implicit_seg = SEG_DATA;
        endcase
    end

    always_comb begin
        case (mode)
            AM_FETCH:   seg_sel = SEG_CODE;
            AM_STACKOP: seg_sel = SEG_STACK;
            AM_STRDST:  seg_sel = SEG_EXTRA;
            default:    seg_sel = ovr_valid ? ovr_sel : implicit_seg;
        endcase
    end

endmodule

// File: rtl/rmag_adder.sv
module rmag_adder #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter bit WRAP  = 1'b0,
    localparam int AW   = OFF_W + SHIFT + 1
) (
    input  logic [OFF_W-1:0] seg_val,
    input  logic [OFF_W-1:0] offset,
    output logic [AW-1:0]    addr
);

    logic [AW-1:0] full_sum;

    always_comb begin
        full_sum = {1'b0, seg_val, {SHIFT{1'b0}}} + {{(SHIFT+1){1'b0}}, offset};
    end

    generate
        if (WRAP) begin : g_fold
            assign addr = {1'b0, full_sum[AW-2:0]};
        end else begin : g_full
            assign addr = full_sum;
        end
    endgenerate

endmodule

// File: rtl/rmag_top.sv
module rmag_top
    import rmag_pkg::*;
#(
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter bit WRAP_1M = 1'b0,
    localparam int AW     = OFF_W + SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [SEG_W-1:0]  seg_wr_sel,
    input  logic [OFF_W-1:0]  seg_wr_data,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              ovr_valid,
    input  logic [SEG_W-1:0]  ovr_sel,
    output logic              out_valid,
    output logic [AW-1:0]     out_addr,
    output logic [SEG_W-1:0]  out_seg
);

    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [SEG_W-1:0] seg;
    } stage_t;

    logic [SEG_N-1:0][OFF_W-1:0] seg_regs;
    logic [SEG_W-1:0]            sel_idx;
    logic [AW-1:0]               sum;
    stage_t                      st_d, st_q;

    rmag_segfile #(.NUM(SEG_N), .DW(OFF_W)) u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_regs)
    );

    rmag_select u_sel (
        .mode      (req_mode),
        .ovr_valid (ovr_valid),
        .ovr_sel   (ovr_sel),
        .seg_sel   (sel_idx)
    );

    rmag_adder #(.OFF_W(OFF_W), .SHIFT(SHIFT), .WRAP(WRAP_1M)) u_add (
        .seg_val (seg_regs[sel_idx]),
        .offset  (req_offset),
        .addr    (sum)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.addr = sum;
            st_d.seg  = sel_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_addr  = st_q.addr;
    assign out_seg   = st_q.seg;

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_seg))); // R4
    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_addr[SHIFT-1:0] == $past(req_offset[SHIFT-1:0])); // R2
    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_FETCH) |=> out_seg == SEG_CODE); // R5
    AST_STACKOP_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_STACKOP) |=> out_seg == SEG_STACK); // R5
    AST_STRDST_ES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == AM_STRDST) |=> out_seg == SEG_EXTRA); // R8
    AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ovr_valid && req_mode > AM_STRDST) |=> out_seg == $past(ovr_sel)); // R9

    always_comb begin
        if (WRAP_1M) begin
            AST_FOLD_TOP: assert (!out_addr[AW-1]); // R3
        end
    end

endmodule

// File: tb/sim_rmag_top.sv
`timescale 1ns/1ps
module sim_rmag_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        v0, v1;
    logic [20:0] a0, a1;
    logic [1:0]  s0, s1;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model [4];
    logic [20:0] last_a0, last_a1;

    always #2 clk = ~clk;

    rmag_top u0 (
        .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
        .seg_wr_data(seg_wr_data), .req_valid(req_valid), .req_mode(req_mode),
        .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .out_valid(v0), .out_addr(a0), .out_seg(s0)
    );

    rmag_top #(.WRAP_1M(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
        .seg_wr_data(seg_wr_data), .req_valid(req_valid), .req_mode(req_mode),
        .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .out_valid(v1), .out_addr(a1), .out_seg(s1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_seg(input logic [3:0] m, input logic ov, input logic [1:0] os);
        case (m)
            4'd0: return 2'd0;
            4'd1: return 2'd2;
            4'd2: return 2'd3;
            default: begin
                if (ov) return os;
                if (m == 4'd3 || m == 4'd4 || m == 4'd8) return 2'd2;
                return 2'd1;
            end
        endcase
    endfunction

    function automatic string mode_tag(input logic [3:0] m, input logic ov);
        if (m <= 4'd1) return "R5";
        if (m == 4'd2) return "R8";
        if (ov) return "R9";
        if (m == 4'd3 || m == 4'd4 || m == 4'd8) return "R6";
        return "R7";
    endfunction

    // called at a negedge; drives one cycle, checks after the next posedge
    task automatic step(input logic wr, input logic [1:0] ws, input logic [15:0] wd,
                        input logic rv, input logic [3:0] m, input logic [15:0] off,
                        input logic ov, input logic [1:0] os);
        logic [1:0]  es;
        logic [20:0] ea;
        string       t;
        seg_wr_en = wr; seg_wr_sel = ws; seg_wr_data = wd;
        req_valid = rv; req_mode = m; req_offset = off; ovr_valid = ov; ovr_sel = os;
        es = exp_seg(m, ov, os);
        ea = {1'b0, model[es], 4'h0} + {5'h0, off};
        t  = mode_tag(m, ov);
        @(negedge clk);
        if (wr) model[ws] = wd;
        if (rv) begin
            chk("R4 valid", {31'd0, v0}, 32'd1);
            chk({t, "/R11 seg"}, {30'd0, s0}, {30'd0, es});
            chk({t, "/R2 addr"}, {11'd0, a0}, {11'd0, ea});
            chk("R3 wrapped addr", {11'd0, a1}, {11'd0, ea & 21'h0FFFFF});
            chk("R3 wrap seg", {30'd0, s1}, {30'd0, es});
        end else begin
            chk("R4 idle valid", {30'd0, v0, v1}, 32'd0);
            chk("R4 hold addr", {11'd0, a0}, {11'd0, last_a0});
            chk("R4 hold wrap addr", {11'd0, a1}, {11'd0, last_a1});
        end
        last_a0 = a0;
        last_a1 = a1;
        seg_wr_en = 1'b0; req_valid = 1'b0; ovr_valid = 1'b0;
    endtask

    task automatic wr_seg(input logic [1:0] ws, input logic [15:0] wd);
        step(1'b1, ws, wd, 1'b0, 4'd0, 16'h0, 1'b0, 2'd0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {31'd0, v0}, 32'd0);
        chk("R1 reset addr", {11'd0, a0}, 32'd0);
        chk("R1 reset seg", {30'd0, s0}, 32'd0);
        rst_n = 1'b1;
        last_a0 = '0;
        last_a1 = '0;
        // R1: segments are zero after reset
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd5, 16'h1234, 1'b0, 2'd0);
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd4, 16'hBEEF, 1'b0, 2'd0);
        // load distinct segments
        wr_seg(2'd0, 16'h1000);
        wr_seg(2'd1, 16'h2000);
        wr_seg(2'd2, 16'h3000);
        wr_seg(2'd3, 16'h4000);
        // R5 R8: override ignored on fixed modes
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd0, 16'h0010, 1'b1, 2'd3);
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd1, 16'h0020, 1'b1, 2'd1);
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd2, 16'h0030, 1'b1, 2'd0);
        // R9 override on operand mode
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd4, 16'h0040, 1'b1, 2'd3);
        // R7 unused mode code
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd15, 16'h0050, 1'b0, 2'd0);
        // R10: same-cycle write uses old value, later request the new one
        step(1'b1, 2'd1, 16'hABCD, 1'b1, 4'd6, 16'h0001, 1'b0, 2'd0);
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd6, 16'h0001, 1'b0, 2'd0);
        // R4 idle hold
        step(1'b0, 2'd0, 16'h0, 1'b0, 4'd0, 16'h0, 1'b0, 2'd0);
        // R2 R3 top corner: 0xFFFF:0xFFFF
        wr_seg(2'd3, 16'hFFFF);
        step(1'b0, 2'd0, 16'h0, 1'b1, 4'd2, 16'hFFFF, 1'b0, 2'd0);
        chk("R2 corner carry", {11'd0, a0}, 32'h0010FFEF);
        chk("R3 corner fold", {11'd0, a1}, 32'h0000FFEF);
        // random mix
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) == 0, 2'($urandom), 16'($urandom),
                 ($urandom % 5) != 0, 4'($urandom), 16'($urandom),
                 ($urandom % 3) == 0, 2'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule